// File: doc/BRIEF.md
# Three-Phase Space-Vector Gate Sequencer with Leg Shoot-Through

This block drives the six gates of a three-phase impedance-network (Z-source) inverter bridge. Once per switching period it captures a sector number, the dwell counts of the two active vectors next to the reference, the count of zero-vector time and a requested shoot-through count, all in clock cycles. It then plays out a symmetric seven-segment vector sequence on a free-running period counter. Part of the zero-vector time is turned into leg shoot-through, where the upper and lower device of one leg conduct together. This boosts the network capacitor voltage while the active-vector timing stays exactly as requested.

The shoot-through budget is limited to the zero time and shared among the three legs, one leg at a time. Complementary devices switch with no dead time, since a leg short is a legal state for this inverter. The controller that computes the counts changes its inputs whenever it likes. The block samples them only at a period boundary, so every period is built from one consistent set.

Top module: `svpwm_zsi_gen`

## Requirements
- R1: While `rst_n` is low, and until the first parameter set is captured, all six gates are off and `prd_start` is low. The first `prd_start` appears in the cycle after the first rising edge with `rst_n` high.
- R2: A period lasts `dwell_a + dwell_b + zero_len` cycles. `prd_start` is high only in the first cycle of each period.
- R3: Leg A is bit 0, leg B is bit 1 and leg C is bit 2. The upper-switch patterns are V1=001, V2=011, V3=010, V4=110, V5=100 and V6=101. V0=000 and V7=111 are the zero vectors. For sector s the period shows Vs for exactly `dwell_a` cycles and V(s mod 6 + 1) for exactly `dwell_b` cycles.
- R4: The cycles spent in a zero vector or in shoot-through add up to exactly `zero_len` per period.
- R5: The ordering is V0, Vs, Vs+1, V7, Vs+1, Vs, V0. The first V0 part lasts floor(zero_len/4) cycles, and the first Vs and Vs+1 parts last floor(dwell_a/2) and floor(dwell_b/2) cycles. When `dwell_a` ≥ 2, the first and the last active cycle of the period are both Vs.
- R6: The shoot-through total S is min(`st_len`, `zero_len`). Legs A and B get floor(S/3) cycles each and leg C gets the rest.
- R7: Shoot-through happens only during zero-vector time and on at most one leg at a time. In it, both devices of that leg are on.
- R8: Outside shoot-through, each running leg has exactly one device on (`gate_lo` = ~`gate_hi`), with no dead time.
- R9: Inputs are sampled only on the last cycle of a period (or at start-up). A change during a period does not alter that period.
- R10: A sector value of 0 or 7 is treated as sector 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_in | input | 3 | Sector number 1..6 |
| dwell_a | input | CW | Cycles of the first active vector |
| dwell_b | input | CW | Cycles of the second active vector |
| zero_len | input | CW | Total zero-vector cycles |
| st_len | input | CW | Requested shoot-through cycles |
| gate_hi | output | 3 | Upper device gates, bit 0 = leg A |
| gate_lo | output | 3 | Lower device gates, bit 0 = leg A |
| prd_start | output | 1 | High in the first cycle of each period |

## Verification
The hardest situation to reach is a period whose inputs are replaced while it is still running. It must still show the old timing in full, including shoot-through clamped against a zero time of only zero or one cycle. The bench writes the next parameter set in the first cycle of every period, so each measured period was disturbed mid-flight. It also sweeps all eight sector codes against dwell, zero and shoot-through counts that include 0, 1, odd values and requests larger than the zero time. Per-vector, per-leg and ordering counts are then compared with arithmetic expectations.

// File: rtl/svpwm_zsi_pkg.sv
package svpwm_zsi_pkg;
    localparam int NLEG = 3;

    // upper-switch pattern of vector code 0..7 (bit 0 = leg A)
    function automatic logic [NLEG-1:0] vec_upper(input logic [2:0] v);
        case (v)
            3'd1:    return 3'b001;
            3'd2:    return 3'b011;
            3'd3:    return 3'b010;
            3'd4:    return 3'b110;
            3'd5:    return 3'b100;
            3'd6:    return 3'b101;
            3'd7:    return 3'b111;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [2:0] sec_next(input logic [2:0] s);
        return (s == 3'd6) ? 3'd1 : s + 3'd1;
    endfunction
endpackage

// File: rtl/svpwm_seg_decode.sv
module svpwm_seg_decode #(
    parameter int CW = 8,
    parameter int PW = CW + 2
) (
    input  logic [PW-1:0] cnt,
    input  logic [2:0]    sec,
    input  logic [CW-1:0] t1,
    input  logic [CW-1:0] t2,
    input  logic [CW-1:0] t0,
    output logic [2:0]    vec,
    output logic          in_zero,
    output logic [PW-1:0] zidx
);
    import svpwm_zsi_pkg::*;

    logic [PW-1:0] qa, hb, hc, mid, e1, e2, e3, e4, e5, e6;

    always_comb begin
        qa  = PW'(t0 >> 2);
        hb  = PW'(t1 >> 1);
        hc  = PW'(t2 >> 1);
        mid = PW'(t0) - (qa << 1);
        e1  = qa;
        e2  = e1 + hb;
        e3  = e2 + hc;
        e4  = e3 + mid;
        e5  = e4 + (PW'(t2) - hc);
        e6  = e5 + (PW'(t1) - hb);

        vec     = 3'd0;
        in_zero = 1'b0;
        zidx    = '0;
        if (cnt < e1) begin
            in_zero = 1'b1;
            zidx    = cnt;
        end else if (cnt < e2) begin
            vec = sec;
        end else if (cnt < e3) begin
            vec = sec_next(sec);
        end else if (cnt < e4) begin
            vec     = 3'd7;
            in_zero = 1'b1;
            zidx    = qa + (cnt - e3);
        end else if (cnt < e5) begin
            vec = sec_next(sec);
        end else if (cnt < e6) begin
            vec = sec;
        end else begin
            in_zero = 1'b1;
            zidx    = qa + mid + (cnt - e6);
        end
    end
endmodule

// File: rtl/svpwm_st_place.sv
module svpwm_st_place #(
    parameter int PW = 10
) (
    input  logic                            in_zero,
    input  logic [PW-1:0]                   zidx,
    input  logic [PW-1:0]                   st_tot,
    output logic [svpwm_zsi_pkg::NLEG-1:0]  st_mask
);
    import svpwm_zsi_pkg::*;

    logic [PW-1:0] share;
    assign share = st_tot / PW'(NLEG);

    for (genvar k = 0; k < NLEG; k++) begin : g_leg
        logic [PW-1:0] lo_b, hi_b;
        assign lo_b = PW'(k) * share;
        assign hi_b = (k == NLEG - 1) ? st_tot : PW'(k + 1) * share;
        assign st_mask[k] = in_zero && (zidx >= lo_b) && (zidx < hi_b);
    end
endmodule

// File: rtl/svpwm_zsi_gen.sv
module svpwm_zsi_gen #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    sec_in,
    input  logic [CW-1:0] dwell_a,
    input  logic [CW-1:0] dwell_b,
    input  logic [CW-1:0] zero_len,
    input  logic [CW-1:0] st_len,
    output logic [2:0]    gate_hi,
    output logic [2:0]    gate_lo,
    output logic          prd_start
);
    import svpwm_zsi_pkg::*;

    localparam int PW = CW + 2;

    typedef struct packed {
        logic          run;
        logic [PW-1:0] cnt;
        logic [PW-1:0] per;
        logic [2:0]    sec;
        logic [CW-1:0] t1;
        logic [CW-1:0] t2;
        logic [CW-1:0] t0;
        logic [CW-1:0] st;
    } gen_state_t;

    gen_state_t st_d, st_q;
    logic       wrap_d;

    always_comb begin
        st_d   = st_q;
        wrap_d = (st_q.cnt + PW'(1)) >= st_q.per;
        if (!st_q.run || wrap_d) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
            st_d.sec = (sec_in == 3'd0 || sec_in == 3'd7) ? 3'd1 : sec_in;
            st_d.t1  = dwell_a;
            st_d.t2  = dwell_b;
            st_d.t0  = zero_len;
            st_d.st  = (st_len > zero_len) ? zero_len : st_len;
            st_d.per = PW'(dwell_a) + PW'(dwell_b) + PW'(zero_len);
        end else begin
            st_d.cnt = st_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [2:0]      vec;
    logic            in_zero;
    logic [PW-1:0]   zidx;
    logic [NLEG-1:0] st_mask;
    logic [NLEG-1:0] upper;

    svpwm_seg_decode #(.CW(CW), .PW(PW)) u_seg (
        .cnt(st_q.cnt), .sec(st_q.sec), .t1(st_q.t1), .t2(st_q.t2), .t0(st_q.t0),
        .vec(vec), .in_zero(in_zero), .zidx(zidx)
    );

    svpwm_st_place #(.PW(PW)) u_st (
        .in_zero(in_zero), .zidx(zidx), .st_tot(PW'(st_q.st)), .st_mask(st_mask)
    );

    assign upper = vec_upper(vec);

    for (genvar k = 0; k < NLEG; k++) begin : g_gate
        assign gate_hi[k] = st_q.run & (upper[k] | st_mask[k]);
        assign gate_lo[k] = st_q.run & (~upper[k] | st_mask[k]);
    end

    assign prd_start = st_q.run && (st_q.cnt == '0);
endmodule

// File: rtl/svpwm_zsi_chk.sv
module svpwm_zsi_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] gate_hi,
    input logic [2:0] gate_lo,
    input logic       prd_start
);
    logic seen_q;
    logic [2:0] both;
    assign both = gate_hi & gate_lo;

    always_ff @(posedge clk) begin
        if (!rst_n)         seen_q <= 1'b0;
        else if (prd_start) seen_q <= 1'b1;
    end

    // R1
    gates_off_in_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (gate_hi == 3'b000) && (gate_lo == 3'b000) && !prd_start);

    // R7
    one_leg_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(both) <= 1);

    // R7
    shoot_in_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (both != 3'b000) |-> (((gate_hi | both) == 3'b111) || ((gate_hi & ~both) == 3'b000)));

    // R8
    legs_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> ((gate_hi | gate_lo) == 3'b111));
endmodule

bind svpwm_zsi_gen svpwm_zsi_chk u_chk (
    .clk(clk), .rst_n(rst_n), .gate_hi(gate_hi), .gate_lo(gate_lo), .prd_start(prd_start)
);

// File: tb/sim_svpwm_zsi_gen.sv
module sim_svpwm_zsi_gen;
    localparam int CW = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n;
    logic [2:0]    sec_in;
    logic [CW-1:0] dwell_a, dwell_b, zero_len, st_len;
    logic [2:0]    gate_hi, gate_lo;
    logic          prd_start;

    svpwm_zsi_gen #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .sec_in(sec_in), .dwell_a(dwell_a), .dwell_b(dwell_b),
        .zero_len(zero_len), .st_len(st_len), .gate_hi(gate_hi), .gate_lo(gate_lo),
        .prd_start(prd_start)
    );

    int errs = 0, checks = 0;
    int c_sec, c_t1, c_t2, c_t0, c_st;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] pat(input int s);
        case (s)
            1: return 3'b001;
            2: return 3'b011;
            3: return 3'b010;
            4: return 3'b110;
            5: return 3'b100;
            default: return 3'b101;
        endcase
    endfunction

    // drive next parameters mid-period, then measure the running period
    task automatic do_case(input int s, input int a, input int b, input int z, input int q);
        int len = 0, nvi = 0, nvj = 0, nzero = 0, na = 0, nb = 0, nc = 0;
        int badst = 0, badcomp = 0, first = 0, last = 0, lead = 0;
        int es, ej, sh, sa, sc;
        logic [2:0] m;
        sec_in = 3'(s); dwell_a = CW'(a); dwell_b = CW'(b); zero_len = CW'(z); st_len = CW'(q);
        es = (c_sec == 0 || c_sec == 7) ? 1 : c_sec;
        ej = (es == 6) ? 1 : es + 1;
        do begin
            len++;
            m = gate_hi & gate_lo;
            if (m != 3'b000) begin
                if (m == 3'b001) na++;
                else if (m == 3'b010) nb++;
                else if (m == 3'b100) nc++;
                else badst++;
                if (first == 0) lead++;
            end else begin
                if (gate_lo != ~gate_hi) badcomp++;
                if (gate_hi == 3'b000 || gate_hi == 3'b111) begin
                    nzero++;
                    if (first == 0) lead++;
                end else if (gate_hi == pat(es)) begin
                    nvi++; last = 1; if (first == 0) first = 1;
                end else if (gate_hi == pat(ej)) begin
                    nvj++; last = 2; if (first == 0) first = 2;
                end else badcomp++;
            end
            @(negedge clk);
        end while (!prd_start && len < 200);
        sh = (c_st > c_t0) ? c_t0 : c_st;
        sa = sh / 3;
        sc = sh - 2 * sa;
        chk(len == c_t1 + c_t2 + c_t0, "R2 period length", len, c_t1 + c_t2 + c_t0);
        chk(nvi == c_t1, (es != c_sec) ? "R10 sector fallback Vs dwell" : "R3 R9 Vs dwell", nvi, c_t1);
        chk(nvj == c_t2, "R3 R9 Vs+1 dwell", nvj, c_t2);
        chk(nzero + na + nb + nc == c_t0, "R4 zero time", nzero + na + nb + nc, c_t0);
        chk(na == sa, "R6 leg A shoot-through", na, sa);
        chk(nb == sa, "R6 leg B shoot-through", nb, sa);
        chk(nc == sc, "R6 leg C shoot-through", nc, sc);
        chk(badst == 0, "R7 shoot-through shape", badst, 0);
        chk(badcomp == 0, "R8 complementary gates", badcomp, 0);
        if (c_t1 + c_t2 > 0) chk(lead == c_t0 / 4, "R5 leading zero part", lead, c_t0 / 4);
        if (c_t1 >= 2) chk(first == 1 && last == 1, "R5 symmetric order", first * 10 + last, 11);
        c_sec = s; c_t1 = a; c_t2 = b; c_t0 = z; c_st = q;
    endtask

    initial begin
        #(8 * 150000);
        errs++; checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int tv1[3] = '{0, 3, 5};
        int tv2[3] = '{0, 2, 7};
        int tz[4]  = '{0, 1, 4, 9};
        int tq[4]  = '{0, 2, 7, 15};
        rst_n = 1'b0;
        c_sec = 2; c_t1 = 3; c_t2 = 2; c_t0 = 4; c_st = 3;
        sec_in = 3'(c_sec); dwell_a = CW'(c_t1); dwell_b = CW'(c_t2);
        zero_len = CW'(c_t0); st_len = CW'(c_st);
        repeat (3) @(negedge clk);
        chk(gate_hi == 3'b000 && gate_lo == 3'b000, "R1 gates off in reset",
            int'({gate_hi, gate_lo}), 0);
        chk(prd_start == 1'b0, "R1 no strobe in reset", int'(prd_start), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(prd_start == 1'b1, "R1 first strobe", int'(prd_start), 1);
        for (int s = 0; s < 8; s++)
            for (int i = 0; i < 3; i++)
                for (int j = 0; j < 3; j++)
                    for (int k = 0; k < 4; k++)
                        for (int n = 0; n < 4; n++)
                            if (tv1[i] + tv2[j] + tz[k] > 0)
                                do_case(s, tv1[i], tv2[j], tz[k], tq[n]);
        do_case(2, 3, 2, 4, 3);
        do_case(2, 3, 2, 4, 3);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule